// File: doc/BRIEF.md
# Transactional Speculative Store Queue

This block holds every store a hardware transaction issues, so that nothing reaches the cache or any other agent until the core declares the transaction committed. The core opens a transaction with `tx_begin`, presents stores one per cycle on the enqueue port, and ends it with either `tx_commit` or `tx_abort`. After a commit the held stores leave through the drain port, oldest first, one per cycle whenever the cache side asserts `dr_ready`. After an abort they are thrown away in a single cycle.

The storage is two banks of `BANK_DEPTH` entries. With `combined_mode` low at the start of a transaction only one bank is used, which models two hardware threads each owning half of the storage. With it high, both banks join into one queue of twice the depth, and consecutive entries alternate between the banks. The block does not stall the core when a store cannot be held. It aborts the transaction and reports why: a store with no valid translation, or one whose address still waits on a missed load, gives the store cause alone. A store with a good translation that finds the queue full gives both the store and the size causes.

Top module: `txn_store_buffer`

## Requirements
- R1: After reset the block is idle: `tx_active`, `dr_valid` and `abort_pulse` are 0, `occupancy` is 0 and `abort_cause` is 2'b00.
- R2: While a transaction is open, `dr_valid` stays 0, whatever stores have been accepted.
- R3: With `combined_mode` low at begin, 16 stores are held (default depth) and the 17th aborts. With it high, 32 are held and the 33rd aborts.
- R4: A store with `st_xlat_ok`=1 and `st_addr_pending`=0 that finds the queue full aborts with `abort_cause`=2'b11 (bit 1 size, bit 0 store).
- R5: A store with `st_xlat_ok`=0 aborts with `abort_cause`=2'b01, whether or not the queue is full.
- R6: A store with `st_addr_pending`=1 aborts with `abort_cause`=2'b01.
- R7: On any abort, the cycle after the triggering edge shows `occupancy`=0, `tx_active`=0, and no held store is ever presented on the drain port.
- R8: After a commit, the held stores appear on `dr_addr`/`dr_data` in the order they were accepted, one leaves per edge at which `dr_ready` is 1, and the output holds steady while `dr_ready` is 0. A store accepted in the same cycle as `tx_commit` is included.
- R9: `tx_begin` has no effect while a drain is in progress or a transaction is already open, and `st_valid` has no effect while idle.
- R10: The bank mode is fixed at `tx_begin`; changing `combined_mode` during a transaction does not change its capacity.
- R11: `abort_pulse` is high for exactly one cycle per abort. An abort requested by the core through `tx_abort` reports `abort_cause`=2'b00, and the cause holds until the next accepted `tx_begin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction (idle only) |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort | input | 1 | Core-requested abort |
| combined_mode | input | 1 | 1 joins both banks; sampled at begin |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_xlat_ok | input | 1 | Address has a valid translation |
| st_addr_pending | input | 1 | Address depends on an unresolved load miss |
| dr_valid | output | 1 | Committed store offered to the cache |
| dr_addr | output | AW | Address of offered store |
| dr_data | output | DW | Data of offered store |
| dr_ready | input | 1 | Cache accepts the offered store |
| tx_active | output | 1 | Transaction open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 2 | Bit 1 size, bit 0 store |
| occupancy | output | $clog2(2*BANK_DEPTH+1) | Entries held |

## Verification
Every result of this block is due one edge after the input that causes it: an accepted store raises `occupancy` at the next edge, a failing store or `tx_abort` shows `abort_pulse`, the cause and a zero count at the next edge, and a commit makes `dr_valid` and the first entry visible at the next edge. The bench drives inputs on the falling edge, steps a behavioural reference of the queue on the rising edge with the same inputs, and compares all outputs at the following falling edge, so each comparison falls exactly one register stage after its stimulus.

// File: rtl/txn_store_buffer.sv
module txn_store_buffer #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BANK_DEPTH = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tx_begin,
  input  logic                                tx_commit,
  input  logic                                tx_abort,
  input  logic                                combined_mode,
  input  logic                                st_valid,
  input  logic [AW-1:0]                       st_addr,
  input  logic [DW-1:0]                       st_data,
  input  logic                                st_xlat_ok,
  input  logic                                st_addr_pending,
  output logic                                dr_valid,
  output logic [AW-1:0]                       dr_addr,
  output logic [DW-1:0]                       dr_data,
  input  logic                                dr_ready,
  output logic                                tx_active,
  output logic                                abort_pulse,
  output logic [1:0]                          abort_cause,
  output logic [$clog2(2*BANK_DEPTH+1)-1:0]   occupancy
);
  localparam int TOT = 2 * BANK_DEPTH;
  localparam int CW  = $clog2(TOT + 1);
  localparam int RW  = $clog2(BANK_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DRAIN} state_t;

  state_t            state;
  logic              mode_q;
  logic [CW-1:0]     wr_cnt, rd_idx;
  logic [AW+DW-1:0]  mem [2][BANK_DEPTH];

  wire [CW-1:0] cap    = mode_q ? CW'(TOT) : CW'(BANK_DEPTH);
  wire          full   = (wr_cnt == cap);
  wire          bad    = !st_xlat_ok || st_addr_pending;
  wire          st_try = (state == S_ACT) && st_valid && !tx_abort;
  wire          st_fail = st_try && (full || bad);
  wire          st_take = st_try && !full && !bad;
  wire [CW-1:0] cnt_nx = wr_cnt + CW'(st_take);

  wire          wr_bank = mode_q & wr_cnt[0];
  wire [RW-1:0] wr_row  = mode_q ? wr_cnt[RW:1] : wr_cnt[RW-1:0];
  wire          rd_bank = mode_q & rd_idx[0];
  wire [RW-1:0] rd_row  = mode_q ? rd_idx[RW:1] : rd_idx[RW-1:0];

  always_ff @(posedge clk)
    if (st_take) mem[wr_bank][wr_row] <= {st_addr, st_data};

  assign {dr_addr, dr_data} = mem[rd_bank][rd_row];
  assign dr_valid  = (state == S_DRAIN);
  assign tx_active = (state == S_ACT);
  assign occupancy = wr_cnt - rd_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      mode_q      <= 1'b0;
      wr_cnt      <= '0;
      rd_idx      <= '0;
      abort_pulse <= 1'b0;
      abort_cause <= 2'b00;
    end else begin
      abort_pulse <= 1'b0;
      case (state)
        S_IDLE: if (tx_begin) begin
          state       <= S_ACT;
          mode_q      <= combined_mode;
          wr_cnt      <= '0;
          rd_idx      <= '0;
          abort_cause <= 2'b00;
        end
        S_ACT: begin
          if (tx_abort || st_fail) begin
            state       <= S_IDLE;
            wr_cnt      <= '0;
            abort_pulse <= 1'b1;
            abort_cause <= tx_abort ? 2'b00 : {full && !bad, 1'b1};
          end else begin
            wr_cnt <= cnt_nx;
            if (tx_commit) state <= (cnt_nx != '0) ? S_DRAIN : S_IDLE;
          end
        end
        S_DRAIN: if (dr_ready) begin
          if (rd_idx + 1'b1 == wr_cnt) begin
            state  <= S_IDLE;
            wr_cnt <= '0;
            rd_idx <= '0;
          end else begin
            rd_idx <= rd_idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txn_store_buffer_chk.sv
module txn_store_buffer_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BANK_DEPTH = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              tx_abort,
  input logic                              st_valid,
  input logic                              st_xlat_ok,
  input logic                              mode_q,
  input logic                              dr_valid,
  input logic                              dr_ready,
  input logic [AW-1:0]                     dr_addr,
  input logic [DW-1:0]                     dr_data,
  input logic                              tx_active,
  input logic                              abort_pulse,
  input logic [1:0]                        abort_cause,
  input logic [$clog2(2*BANK_DEPTH+1)-1:0] occupancy
);
  p_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !dr_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= (mode_q ? 2*BANK_DEPTH : BANK_DEPTH));

  p_size_with_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause[1]) |-> abort_cause[0]);

  p_no_xlat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && st_valid && !st_xlat_ok && !tx_abort) |=> (abort_pulse && abort_cause == 2'b01));

  p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (occupancy == '0 && !tx_active && !dr_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
endmodule

bind txn_store_buffer txn_store_buffer_chk #(.AW(AW), .DW(DW), .BANK_DEPTH(BANK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_abort(tx_abort), .st_valid(st_valid),
  .st_xlat_ok(st_xlat_ok), .mode_q(mode_q), .dr_valid(dr_valid),
  .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
  .tx_active(tx_active), .abort_pulse(abort_pulse),
  .abort_cause(abort_cause), .occupancy(occupancy)
);

// File: tb/sim_txn_store_buffer.sv
module sim_txn_store_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, BD = 16;
  localparam int CW = $clog2(2*BD+1);

  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, tx_commit = 0, tx_abort = 0, combined_mode = 0;
  logic st_valid = 0, st_xlat_ok = 1, st_addr_pending = 0, dr_ready = 0;
  logic [AW-1:0] st_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic dr_valid, tx_active, abort_pulse;
  logic [AW-1:0] dr_addr;
  logic [DW-1:0] dr_data;
  logic [1:0] abort_cause;
  logic [CW-1:0] occupancy;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_store_buffer #(.AW(AW), .DW(DW), .BANK_DEPTH(BD)) u0 (.*);

  // behavioural reference
  int m_state = 0;
  bit m_mode = 0, m_pulse = 0;
  int m_cause = 0;
  logic [AW+DW-1:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_mode = 0; m_pulse = 0; m_cause = 0; m_q.delete();
    end else begin
      m_pulse = 0;
      if (m_state == 0) begin
        if (tx_begin) begin m_state = 1; m_mode = combined_mode; m_cause = 0; m_q.delete(); end
      end else if (m_state == 1) begin
        bit ab, full, bad;
        ab = 0;
        full = m_q.size() >= (m_mode ? 2*BD : BD);
        bad = !st_xlat_ok || st_addr_pending;
        if (tx_abort) begin ab = 1; m_cause = 0; end
        else if (st_valid) begin
          if (full || bad) begin ab = 1; m_cause = ((full && !bad) ? 2 : 0) + 1; end
          else m_q.push_back({st_addr, st_data});
        end
        if (ab) begin m_state = 0; m_pulse = 1; m_q.delete(); end
        else if (tx_commit) m_state = (m_q.size() > 0) ? 2 : 0;
      end else begin
        if (dr_ready) begin void'(m_q.pop_front()); if (m_q.size() == 0) m_state = 0; end
      end
    end
  end

  task automatic check(string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("tx_active", tx_active, m_state == 1);
    check("dr_valid", dr_valid, m_state == 2);
    check("occupancy", occupancy, m_q.size());
    check("abort_pulse", abort_pulse, m_pulse);
    check("abort_cause", abort_cause, m_cause);
    if (dr_valid && m_q.size() > 0) check("drain entry", {dr_addr, dr_data}, m_q[0]);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic begin_tx(bit comb);
    combined_mode = comb; tx_begin = 1; tick(); tx_begin = 0;
  endtask

  task automatic store(int a, bit xl = 1, bit pend = 0);
    st_valid = 1; st_addr = AW'(a); st_data = DW'(32'hA5000000 ^ (a * 32'h01010101));
    st_xlat_ok = xl; st_addr_pending = pend; tick();
    st_valid = 0; st_xlat_ok = 1; st_addr_pending = 0;
  endtask

  task automatic commit_with_store(int a);
    tx_commit = 1; store(a); tx_commit = 0;
  endtask

  task automatic drain_all(bit toggle);
    int n = 0;
    while (dr_valid && n < 200) begin
      dr_ready = toggle ? n[0] : 1'b1; tick(); n++;
    end
    dr_ready = 0; tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    cur_req = "R1";
    check("reset tx_active", tx_active, 0);
    check("reset dr_valid", dr_valid, 0);
    check("reset occupancy", occupancy, 0);
    check("reset cause", abort_cause, 0);
    rst_n = 1; tick();

    cur_req = "R9 idle store";
    store(7); check("idle store ignored", occupancy, 0);

    cur_req = "R2 R8 split drain";
    begin_tx(0);
    for (int i = 0; i < 5; i++) store(16'h100 + i);
    check("R2 hidden", dr_valid, 0);
    commit_with_store(16'h1FF);
    check("R8 six held", occupancy, 6);
    cur_req = "R9 begin in drain";
    tx_begin = 1; tick(); tx_begin = 0;
    cur_req = "R8 toggled ready";
    drain_all(1);
    check("R8 idle after drain", occupancy, 0);

    cur_req = "R3 R4 split overflow";
    begin_tx(0);
    for (int i = 0; i < 16; i++) store(16'h200 + i);
    check("R3 sixteen held", occupancy, 16);
    store(16'h2FF);
    check("R4 cause size|store", abort_cause, 3);
    check("R7 discarded", occupancy, 0);
    tick(); check("R11 cause held", abort_cause, 3);

    cur_req = "R3 R10 combined capacity";
    begin_tx(1);
    for (int i = 0; i < 32; i++) begin combined_mode = i[0]; store(16'h300 + i * 3); end
    check("R3 thirty-two held", occupancy, 32);
    cur_req = "R8 combined drain";
    tx_commit = 1; tick(); tx_commit = 0;
    drain_all(0);

    cur_req = "R3 R4 combined overflow";
    begin_tx(1);
    for (int i = 0; i < 33; i++) store(16'h400 + i);
    check("R4 cause", abort_cause, 3);

    cur_req = "R10 split fixed";
    begin_tx(0); combined_mode = 1;
    for (int i = 0; i < 17; i++) store(16'h500 + i);
    check("R10 capacity stays 16", abort_cause, 3);

    cur_req = "R5 no translation";
    begin_tx(0);
    store(16'h600); store(16'h601, 0);
    check("R5 cause store", abort_cause, 1);
    begin_tx(0);
    for (int i = 0; i < 16; i++) store(16'h610 + i);
    store(16'h620, 0);
    check("R5 full no translation", abort_cause, 1);

    cur_req = "R6 pending address";
    begin_tx(1);
    store(16'h700); store(16'h701, 1, 1);
    check("R6 cause store", abort_cause, 1);
    check("R7 discarded", dr_valid, 0);

    cur_req = "R7 R11 core abort";
    begin_tx(0);
    store(16'h800); store(16'h801);
    tx_abort = 1; tick(); tx_abort = 0;
    check("R11 cause none", abort_cause, 0);
    check("R7 occupancy", occupancy, 0);
    tick(); check("R11 pulse single", abort_pulse, 0);
    dr_ready = 1; repeat (3) tick(); dr_ready = 0;
    check("R7 nothing drains", dr_valid, 0);

    cur_req = "R8 empty commit";
    begin_tx(0);
    tx_commit = 1; tick(); tx_commit = 0;
    check("R8 empty to idle", tx_active, 0);
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule